// File: doc/BRIEF.md
# Countdown Guard Timer

The guard timer is a software-fed timer behind a 32-bit register interface. A down-counter loses one on every clock cycle. Software must keep rewriting it so that it never runs out. When the count is zero, the timer expires and takes a `granted` output low. The output then stays low, even after the counter is reloaded, until software writes a self-clearing restore bit. A status bit reads back the level of `granted`, and a constant register gives the clock frequency in Hz so that software can turn time into counts.

The bus side is a plain single-cycle strobe. A write takes effect on the clock edge where `wr_en` is high. Read data is combinational from `addr` and the current register state. Three word offsets are decoded: 0x20 is the clock frequency, 0x24 is status/control and 0x28 is the counter. These offsets are kept because software decodes them.

Top module: `guard_timer`

## Requirements
- R1: After a synchronous active-low reset, `granted` is 0 and the counter (offset 0x28) reads 0, so software must both load and restore before the output is granted.
- R2: Offset 0x20 reads the parameter CLK_HZ (default 50,000,000), and writes to it have no effect.
- R3: A write to offset 0x28 loads the counter with the write data on that edge. While the counter is nonzero and not being written, it decreases by exactly one per cycle. A read of 0x28 returns the live count.
- R4: When the counter is 0 and not being written, it stays at 0 and does not wrap.
- R5: On the first clock edge where the counter is 0 and no restore is written, `granted` goes to 0.
- R6: While `granted` is 0, it stays 0 unless a restore is written. Loading the counter alone does not raise it.
- R7: A write to offset 0x24 with bit 1 set raises `granted` on that edge. Bit 1 always reads back as 0 (self-clearing).
- R8: Bit 0 of offset 0x24 reads the current level of `granted`, and bits 31..1 read 0.
- R9: A restore written while the counter is 0 raises `granted` for exactly one cycle, after which it expires again.
- R10: Reads of any offset other than 0x20, 0x24 and 0x28 return 0, and writes to them change nothing.
- R11: A write to offset 0x24 with bit 1 clear leaves `granted` and the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| addr | input | ADDR_W (8) | Byte offset of the register accessed |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data for `addr`, combinational |
| granted | output | 1 | High while the timer is fed and restored; low after expiry |

## Verification
The properties assume that the bus presents at most one write per cycle and that the write strobe, offset and data are stable across the sampling edge. With these assumptions, a counter load and a restore can never fall on the same edge. The bench changes every input only on the falling clock edge and issues exactly one access per vector, so it stays within these assumptions. It also covers both sides of the one-cycle gap between the count reaching zero and the output falling.

// File: rtl/guard_timer_pkg.sv
// Package: shared offsets and bit positions of the guard timer register window.
// Assumes byte addressing with 32-bit word registers.
package guard_timer_pkg;

    localparam int unsigned OFS_CLK_HZ = 32'h20;  // constant clock-frequency word
    localparam int unsigned OFS_CTRL   = 32'h24;  // status / control word
    localparam int unsigned OFS_COUNT  = 32'h28;  // live down-counter

    localparam int unsigned BIT_GRANT  = 0;       // status: level of granted
    localparam int unsigned BIT_REARM  = 1;       // control: write 1 to restore

    // decoded write actions of one bus cycle
    typedef struct packed {
        logic load_count;
        logic rearm;
    } wr_action_t;

endpackage

// File: rtl/guard_decode.sv
// Write decoder: turns one bus write into at most one action.
// Assumes one write per cycle; writes to unmapped offsets produce no action.
module guard_decode
    import guard_timer_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rearm_bit,
    output wr_action_t        action
);

    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);

    // decode the strobe and offset into load / restore pulses
    always_comb begin
        action.load_count = wr_en && (addr == A_COUNT);
        action.rearm      = wr_en && (addr == A_CTRL) && rearm_bit;
    end

endmodule

// File: rtl/guard_countdown.sv
// Down-counter: loads on request, otherwise steps down by one and saturates at zero.
// Assumes the load value is already aligned to DATA_W.
module guard_countdown #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] count,
    output logic              at_zero
);

    logic [DATA_W-1:0] count_q;

    // count register: reset to zero, load has priority over stepping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (count_q != '0) begin
            count_q <= count_q - DATA_W'(1);
        end
    end

    // expose count and its zero flag
    always_comb begin
        count   = count_q;
        at_zero = (count_q == '0);
    end

endmodule

// File: rtl/guard_latch.sv
// Grant latch: set by a restore, cleared on any edge where the count is zero.
// Assumes restore and expiry are sampled on the same edge; restore wins that edge.
module guard_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic rearm,
    input  logic expired,
    output logic granted
);

    logic granted_q;

    // granted register: reset low, restore sets, expiry clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            granted_q <= 1'b0;
        end else if (rearm) begin
            granted_q <= 1'b1;
        end else if (expired) begin
            granted_q <= 1'b0;
        end
    end

    assign granted = granted_q;

endmodule

// File: rtl/guard_readmux.sv
// Read multiplexer: combinational read data for the three mapped words.
// Assumes unmapped offsets read zero; the restore bit is never stored so reads 0.
module guard_readmux
    import guard_timer_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CLK_HZ = 50_000_000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] count,
    input  logic              granted,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] A_CLK   = ADDR_W'(OFS_CLK_HZ);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
    localparam logic [DATA_W-1:0] CLK_WORD = DATA_W'(CLK_HZ);

    // select the word addressed, zero elsewhere
    always_comb begin
        rdata = '0;
        case (addr)
            A_CLK:   rdata = CLK_WORD;
            A_CTRL:  rdata[BIT_GRANT] = granted;
            A_COUNT: rdata = count;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/guard_timer.sv
// Top: countdown guard timer with latched grant output and restore bit.
// Assumes a single-cycle write strobe and combinational reads.
module guard_timer
    import guard_timer_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CLK_HZ = 50_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              granted
);

    wr_action_t        act;
    logic [DATA_W-1:0] count_q;
    logic              count_zero;

    guard_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr_en     (wr_en),
        .addr      (addr),
        .rearm_bit (wdata[BIT_REARM]),
        .action    (act)
    );

    guard_countdown #(.DATA_W(DATA_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (act.load_count),
        .load_val (wdata),
        .count    (count_q),
        .at_zero  (count_zero)
    );

    guard_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .rearm   (act.rearm),
        .expired (count_zero),
        .granted (granted)
    );

    guard_readmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_HZ(CLK_HZ)) u_rd (
        .addr    (addr),
        .count   (count_q),
        .granted (granted),
        .rdata   (rdata)
    );

endmodule

// File: rtl/guard_timer_chk.sv
// Checker: temporal properties of the guard timer, bound to the top module.
// Assumes at most one write per cycle (load and restore never coincide).
module guard_timer_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load,
    input logic              rearm,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] count,
    input logic              granted
);

    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(wdata));

    assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && count != '0) |=> count == $past(count) - DATA_W'(1));

    assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && count == '0) |=> count == '0);

    assert_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rearm && count == '0) |=> !granted);

    assert_stay_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rearm && !granted) |=> !granted);

    assert_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> granted);

endmodule

bind guard_timer guard_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (act.load_count),
    .rearm   (act.rearm),
    .wdata   (wdata),
    .count   (count_q),
    .granted (granted)
);

// File: tb/test_guard_timer.sv
// Bench: vector table walked once, then directed reset and unmapped-offset tests.
module test_guard_timer;

    localparam logic [1:0] OP_IDLE = 2'd0;
    localparam logic [1:0] OP_RD   = 2'd1;
    localparam logic [1:0] OP_WR   = 2'd2;
    localparam logic [31:0] HZ     = 32'd50_000_000;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp_rd;
        logic        exp_g;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 32;
    // expected values are observed before the edge that the same vector drives
    localparam vec_t VECS [0:NV-1] = '{
        '{OP_RD,   8'h28, 32'h0,          32'h0,          1'b0, 4'd1},  // R1 count 0
        '{OP_RD,   8'h24, 32'h0,          32'h0,          1'b0, 4'd1},  // R1 not granted
        '{OP_RD,   8'h20, 32'h0,          HZ,             1'b0, 4'd2},  // R2 frequency
        '{OP_WR,   8'h20, 32'h1234,       32'h0,          1'b0, 4'd2},  // R2 write ignored
        '{OP_RD,   8'h20, 32'h0,          HZ,             1'b0, 4'd2},  // R2
        '{OP_WR,   8'h28, 32'd10,         32'h0,          1'b0, 4'd3},  // R3 load
        '{OP_RD,   8'h28, 32'h0,          32'd10,         1'b0, 4'd3},  // R3
        '{OP_RD,   8'h28, 32'h0,          32'd9,          1'b0, 4'd6},  // R3 R6 still low
        '{OP_WR,   8'h24, 32'h2,          32'h0,          1'b0, 4'd7},  // R7 restore
        '{OP_RD,   8'h24, 32'h0,          32'h1,          1'b1, 4'd8},  // R7 R8 bit1 reads 0
        '{OP_WR,   8'h28, 32'd3,          32'h0,          1'b1, 4'd3},  // R3 reload
        '{OP_RD,   8'h28, 32'h0,          32'd3,          1'b1, 4'd3},
        '{OP_IDLE, 8'h00, 32'h0,          32'h0,          1'b1, 4'd3},
        '{OP_RD,   8'h28, 32'h0,          32'd1,          1'b1, 4'd3},
        '{OP_RD,   8'h28, 32'h0,          32'd0,          1'b1, 4'd5},  // R5 zero, not yet fired
        '{OP_RD,   8'h28, 32'h0,          32'd0,          1'b0, 4'd4},  // R4 R5 fired, no wrap
        '{OP_RD,   8'h24, 32'h0,          32'h0,          1'b0, 4'd8},  // R8
        '{OP_WR,   8'h28, 32'd5,          32'h0,          1'b0, 4'd6},  // R6 load alone
        '{OP_RD,   8'h28, 32'h0,          32'd5,          1'b0, 4'd6},  // R6
        '{OP_WR,   8'h24, 32'hFFFF_FFFD,  32'h0,          1'b0, 4'd11}, // R11 bit1 clear
        '{OP_RD,   8'h24, 32'h0,          32'h0,          1'b0, 4'd11}, // R11
        '{OP_WR,   8'h10, 32'hFF,         32'h0,          1'b0, 4'd10}, // R10 unmapped write
        '{OP_RD,   8'h10, 32'h0,          32'h0,          1'b0, 4'd10}, // R10
        '{OP_RD,   8'h28, 32'h0,          32'h0,          1'b0, 4'd4},  // R4 R11 count undisturbed
        '{OP_WR,   8'h24, 32'h2,          32'h0,          1'b0, 4'd9},  // R9 restore at zero
        '{OP_RD,   8'h24, 32'h0,          32'h1,          1'b1, 4'd9},  // R9 one cycle high
        '{OP_RD,   8'h24, 32'h0,          32'h0,          1'b0, 4'd9},  // R9 fired again
        '{OP_WR,   8'h28, 32'hFFFF_FFFF,  32'h0,          1'b0, 4'd3},  // R3 full-scale load
        '{OP_RD,   8'h28, 32'h0,          32'hFFFF_FFFF,  1'b0, 4'd3},
        '{OP_WR,   8'h24, 32'h2,          32'h0,          1'b0, 4'd7},  // R7
        '{OP_RD,   8'h28, 32'h0,          32'hFFFF_FFFD,  1'b1, 4'd3},
        '{OP_RD,   8'h24, 32'h0,          32'h1,          1'b1, 4'd8}   // R8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        granted;

    int applied = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    guard_timer i_guard_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .granted (granted)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // drive one access at the falling edge and sample outputs shortly after
    task automatic access(input logic [1:0] op, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = (op == OP_WR);
        addr  = a;
        wdata = d;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].op, VECS[i].addr, VECS[i].data);
            check($sformatf("R%0d granted vec %0d", VECS[i].req, i),
                  {31'b0, granted}, {31'b0, VECS[i].exp_g});
            if (VECS[i].op == OP_RD)
                check($sformatf("R%0d rdata vec %0d", VECS[i].req, i), rdata, VECS[i].exp_rd);
        end

        // R1: reset while granted and counting
        access(OP_IDLE, 8'h00, 32'h0);
        rst_n = 1'b0;
        repeat (2) access(OP_IDLE, 8'h00, 32'h0);
        check("R1 granted after reset", {31'b0, granted}, 32'h0);
        access(OP_RD, 8'h28, 32'h0);
        check("R1 count after reset", rdata, 32'h0);
        rst_n = 1'b1;

        // R10: other unmapped offsets read zero
        access(OP_RD, 8'h2C, 32'h0);
        check("R10 offset 0x2C", rdata, 32'h0);
        access(OP_RD, 8'h00, 32'h0);
        check("R10 offset 0x00", rdata, 32'h0);

        // R6 and R7 after reset: load, then restore grants
        access(OP_WR, 8'h28, 32'd20);
        access(OP_IDLE, 8'h00, 32'h0);
        check("R6 load alone after reset", {31'b0, granted}, 32'h0);
        access(OP_WR, 8'h24, 32'h2);
        access(OP_RD, 8'h24, 32'h0);
        check("R7 restore after reset", rdata, 32'h1);

        access(OP_IDLE, 8'h00, 32'h0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
            $finish;
        end
    end

endmodule